// File: doc/BRIEF.md
# Burst Block-Transfer Host

This block is a host on a memory-mapped burst bus. It moves a block of words between a local stream and a memory agent. A one-cycle command gives a start address, a word count, a direction and a byte mask. For one command the host places a single request on the bus. A read is one request cycle followed by separately counted data returns. A write is one address followed by as many data beats as the count says. When the whole block has moved, the host pulses `done`.

Write data comes from a source stream that is always ready. The host presents a word and raises `src_pop` on each cycle in which it takes one. Words returned by a read leave on `rd_data`/`rd_valid`, one cycle after the bus edge that carried them. A command that asks for zero words never reaches the bus.

Top module: `burst_host`

## Requirements
- R1: After reset, `av_read`, `av_write`, `busy`, `done` and `rd_valid` are all low.
- R2: While `av_waitrequest` is high during a request, `av_address`, `av_read`/`av_write`, `av_writedata`, `av_burstcount` and `av_byteenable` keep their values into the next cycle.
- R3: A bus beat is accepted only on a rising edge where the request is high and `av_waitrequest` is low. The agent receives exactly `go_len` write beats per write command, whatever the stall pattern.
- R4: Each burst carries one start address, equal to `go_addr`. `av_burstcount` equals `go_len` and stays constant for every beat of the burst.
- R5: For a read, `av_read` rises in the cycle after `go` and falls in the cycle after the edge that accepts it. Each read command produces exactly one accepted read request.
- R6: Each word taken on an edge with `av_readdatavalid` high during a read appears on `rd_data` with `rd_valid` high in the following cycle. Words keep their arrival order, and exactly `go_len` words are delivered.
- R7: Write data is taken from `src_data` in stream order, one word per beat, with exactly one `src_pop` cycle per beat. The word for beat k+1 is taken in the cycle in which beat k is accepted.
- R8: `av_byteenable` carries `go_mask`, with one bit per 8 data bits; bit 0 enables the lowest byte.
- R9: A `go` with `go_len` of 0 issues no bus request, and `done` is high in the cycle after `go`.
- R10: `av_read` and `av_write` are never high together, and `av_burstcount` is never 0 while either is high.
- R11: A `go` while `busy` is high is ignored. `av_readdatavalid` outside a read produces no `rd_valid`.
- R12: `done` is a single-cycle pulse. For a write it comes in the cycle after the last beat is accepted. For a read it coincides with the last `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Command strobe, one cycle |
| go_addr | input | ADDR_W | Burst start address |
| go_len | input | CNT_W | Number of words to move |
| go_write | input | 1 | 1 = write burst, 0 = read burst |
| go_mask | input | DATA_W/8 | Byte enables for the burst |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| src_data | input | DATA_W | Next write word from the source stream |
| src_pop | output | 1 | The host takes `src_data` this cycle |
| rd_data | output | DATA_W | Returned read word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| av_address | output | ADDR_W | Bus address |
| av_read | output | 1 | Bus read request |
| av_write | output | 1 | Bus write request |
| av_writedata | output | DATA_W | Bus write data |
| av_burstcount | output | CNT_W | Words in the burst |
| av_byteenable | output | DATA_W/8 | Bus byte enables |
| av_waitrequest | input | 1 | Agent stall |
| av_readdata | input | DATA_W | Agent read data |
| av_readdatavalid | input | 1 | Agent read data is valid |

## Verification
The bench builds the host with DATA_W of 32, so there are four enable bits and sparse masks such as 0x5 and 0x1 can be told apart. CNT_W is 4, so the largest legal burst of 15 beats is exercised along with bursts of one beat and zero words. ADDR_W is 16. A bench agent with a rotating stall pattern and a separate gap pattern on read returns holds requests across stalls at every beat position. It keeps acceptance, beat counting and out-of-step data returns visibly apart.

// File: rtl/bmh_pkg.sv
package bmh_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_RREQ  = 2'd2,
        PH_RRESP = 2'd3
    } phase_e;

endpackage

// File: rtl/bmh_beat_counter.sv
module bmh_beat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] remain,
    output logic         at_last
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign remain  = cnt_q;
    assign at_last = (cnt_q == W'(1));

    // R3: a beat is only ever counted while some remain
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

endmodule

// File: rtl/bmh_resp_capture.sv
module bmh_resp_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] word_out,
    output logic          valid_out
);

    logic [DW-1:0] word_d, word_q;
    logic          vld_d, vld_q;

    always_comb begin
        vld_d  = take;
        word_d = take ? word_in : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            word_q <= word_d;
            vld_q  <= vld_d;
        end
    end

    assign word_out  = word_q;
    assign valid_out = vld_q;

endmodule

// File: rtl/burst_host.sv
module burst_host
    import bmh_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  ADDR_W = 32,
    parameter int  CNT_W  = 8,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [CNT_W-1:0]  go_len,
    input  logic              go_write,
    input  logic [BE_W-1:0]   go_mask,
    output logic              busy,
    output logic              done,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] av_address,
    output logic              av_read,
    output logic              av_write,
    output logic [DATA_W-1:0] av_writedata,
    output logic [CNT_W-1:0]  av_burstcount,
    output logic [BE_W-1:0]   av_byteenable,
    input  logic              av_waitrequest,
    input  logic [DATA_W-1:0] av_readdata,
    input  logic              av_readdatavalid
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  burst;
        logic [BE_W-1:0]   mask;
        logic [DATA_W-1:0] wdata;
        logic              done;
    } regs_t;

    regs_t            q, d;
    logic             ctr_load, ctr_dec, ctr_last, resp_take;
    logic [CNT_W-1:0] ctr_remain;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        ctr_load = 1'b0;
        ctr_dec  = 1'b0;
        src_pop  = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (go) begin
                    if (go_len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.addr   = go_addr;
                        d.burst  = go_len;
                        d.mask   = go_mask;
                        ctr_load = 1'b1;
                        if (go_write) begin
                            d.phase = PH_WRITE;
                            d.wdata = src_data;
                            src_pop = 1'b1;
                        end else begin
                            d.phase = PH_RREQ;
                        end
                    end
                end
            end
            PH_WRITE: begin
                if (!av_waitrequest) begin
                    ctr_dec = 1'b1;
                    if (ctr_last) begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.wdata = src_data;
                        src_pop = 1'b1;
                    end
                end
            end
            PH_RREQ: begin
                if (!av_waitrequest) begin
                    d.phase = PH_RRESP;
                end
            end
            PH_RRESP: begin
                if (av_readdatavalid) begin
                    ctr_dec = 1'b1;
                    if (ctr_last) begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    bmh_beat_counter #(.W(CNT_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (go_len),
        .dec      (ctr_dec),
        .remain   (ctr_remain),
        .at_last  (ctr_last)
    );

    assign resp_take = (q.phase == PH_RRESP) && av_readdatavalid;

    bmh_resp_capture #(.DW(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (resp_take),
        .word_in   (av_readdata),
        .word_out  (rd_data),
        .valid_out (rd_valid)
    );

    assign busy          = (q.phase != PH_IDLE);
    assign done          = q.done;
    assign av_address    = q.addr;
    assign av_write      = (q.phase == PH_WRITE);
    assign av_read       = (q.phase == PH_RREQ);
    assign av_writedata  = q.wdata;
    assign av_burstcount = q.burst;
    assign av_byteenable = q.mask;

    // R2: a stalled write keeps every request field
    a_r2_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (av_write && av_waitrequest) |=> (av_write && $stable(av_address)
        && $stable(av_writedata) && $stable(av_burstcount) && $stable(av_byteenable)));

    // R2: a stalled read keeps every request field
    a_r2_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (av_read && av_waitrequest) |=> (av_read && $stable(av_address)
        && $stable(av_burstcount) && $stable(av_byteenable)));

    // R4: address and count stay fixed across the beats of a write burst
    a_r4_addr_const: assert property (@(posedge clk) disable iff (!rst_n)
        (av_write && $past(av_write)) |-> ($stable(av_address) && $stable(av_burstcount)));

    // R5: read drops right after it is accepted
    a_r5_read_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (av_read && !av_waitrequest) |=> !av_read);

    // R10: never both commands, never an empty burst
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(av_read && av_write) && (!(av_read || av_write) || (av_burstcount != '0)));

    // R11: returned words leave only while a read is in progress
    a_r11_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(busy) && !$past(go && !busy)));

endmodule

// File: tb/burst_host_bench.sv
`timescale 1ns/1ps
module burst_host_bench;

    localparam int DW = 32;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [AW-1:0] go_addr = '0;
    logic [CW-1:0] go_len = '0;
    logic          go_write = 1'b0;
    logic [BW-1:0] go_mask = '0;
    logic          busy, done, src_pop, rd_valid;
    logic [DW-1:0] src_data, rd_data;
    logic [AW-1:0] av_address;
    logic          av_read, av_write, av_waitrequest, av_readdatavalid;
    logic [DW-1:0] av_writedata, av_readdata;
    logic [CW-1:0] av_burstcount;
    logic [BW-1:0] av_byteenable;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    burst_host #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u_burst_host (
        .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .go_len(go_len),
        .go_write(go_write), .go_mask(go_mask), .busy(busy), .done(done),
        .src_data(src_data), .src_pop(src_pop), .rd_data(rd_data), .rd_valid(rd_valid),
        .av_address(av_address), .av_read(av_read), .av_write(av_write),
        .av_writedata(av_writedata), .av_burstcount(av_burstcount),
        .av_byteenable(av_byteenable), .av_waitrequest(av_waitrequest),
        .av_readdata(av_readdata), .av_readdatavalid(av_readdatavalid)
    );

    // source stream
    int src_idx;
    assign src_data = 32'hA500_0000 + src_idx;
    always @(posedge clk or negedge rst_n)
        if (!rst_n) src_idx <= 0; else if (src_pop) src_idx <= src_idx + 1;

    // agent model
    logic [15:0] wpat_cfg = '0;
    logic [15:0] gap_cfg = '0;
    logic        stray = 1'b0;
    logic [3:0]  ph;
    logic [DW-1:0] mem [0:255];
    logic [7:0]  wbeat, rbase, ridx;
    logic [CW-1:0] rleft, wcnt_cap;
    logic [BW-1:0] wbe_cap;
    logic [AW-1:0] waddr_cap;
    logic        rdv, addr_bad;
    logic [DW-1:0] rdat;
    int wtotal, rcmds;

    function automatic logic [DW-1:0] pattern(input int a);
        return 32'h5EED_0000 ^ (a * 32'h0101_0103);
    endfunction

    assign av_waitrequest   = wpat_cfg[ph];
    assign av_readdatavalid = rdv | stray;
    assign av_readdata      = rdat;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pattern(i);
            ph <= '0; wbeat <= '0; rleft <= '0; ridx <= '0; rbase <= '0;
            rdv <= 1'b0; rdat <= '0; addr_bad <= 1'b0; wtotal <= 0; rcmds <= 0;
            wcnt_cap <= '0; wbe_cap <= '0; waddr_cap <= '0;
        end else begin
            ph  <= ph + 4'd1;
            rdv <= 1'b0;
            if (av_write && !av_waitrequest) begin
                if (wbeat == 0) begin
                    wcnt_cap <= av_burstcount; wbe_cap <= av_byteenable; waddr_cap <= av_address;
                end else if (av_address != waddr_cap || av_burstcount != wcnt_cap) begin
                    addr_bad <= 1'b1;
                end
                mem[8'(av_address[7:0] + wbeat)] <= av_writedata;
                wbeat  <= (wbeat + 8'd1 == 8'(av_burstcount)) ? 8'd0 : wbeat + 8'd1;
                wtotal <= wtotal + 1;
            end
            if (av_read && !av_waitrequest) begin
                rbase <= av_address[7:0]; rleft <= av_burstcount; ridx <= '0;
                rcmds <= rcmds + 1; wcnt_cap <= av_burstcount;
            end else if (rleft != 0 && !gap_cfg[ph]) begin
                rdv   <= 1'b1;
                rdat  <= mem[8'(rbase + ridx)];
                ridx  <= ridx + 8'd1;
                rleft <= rleft - 1'b1;
            end
        end
    end

    // output stream monitor
    logic [DW-1:0] cap [0:63];
    int cap_n = 0;
    always @(negedge clk) if (rd_valid && cap_n < 64) begin cap[cap_n] = rd_data; cap_n++; end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_go(input logic [AW-1:0] a, input int n, input bit w, input logic [BW-1:0] m);
        @(negedge clk);
        go = 1'b1; go_addr = a; go_len = CW'(n); go_write = w; go_mask = m;
        @(negedge clk);
        go = 1'b0;
    endtask

    // waits for done; returns rd_valid seen with it
    task automatic wait_done(input string req, output bit rv_at_done);
        int t = 0;
        rv_at_done = 1'b0;
        while (!done && t < 2000) begin @(negedge clk); t++; end
        chk(done, req, {63'd0, done}, 64'd1);
        rv_at_done = rd_valid;
        @(negedge clk);
        chk(!done, "R12 pulse", {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        chk(!av_read && !av_write, "R1 bus idle", {av_read, av_write}, 0);
        chk(!busy && !done && !rd_valid, "R1 status", {busy, done, rd_valid}, 0);
    endtask

    task automatic t_zero();
        int w0 = wtotal, r0 = rcmds;
        @(negedge clk);
        go = 1'b1; go_addr = 16'h0040; go_len = '0; go_write = 1'b1; go_mask = '1;
        @(negedge clk);
        go = 1'b0;
        chk(done && !busy, "R9 done next cycle", {done, busy}, 2'b10);
        chk(!av_read && !av_write, "R9 no request", {av_read, av_write}, 0);
        @(negedge clk);
        chk(!done, "R12 zero pulse", done, 0);
        repeat (3) @(negedge clk);
        chk(wtotal == w0 && rcmds == r0, "R9 no beats", wtotal - w0, 0);
    endtask

    task automatic t_write(input int a, input int n, input logic [BW-1:0] m, input logic [15:0] wp);
        int w0, s0, sent_before;
        bit rv;
        logic [DW-1:0] sentinel;
        wpat_cfg = wp;
        @(negedge clk);
        w0 = wtotal; s0 = src_idx; sentinel = mem[8'(a + n)];
        pulse_go(AW'(a), n, 1'b1, m);
        wait_done("R12 write done", rv);
        chk(wtotal - w0 == n, "R3 beat count", wtotal - w0, n);
        chk(src_idx - s0 == n, "R7 pops", src_idx - s0, n);
        chk(wcnt_cap == CW'(n) && waddr_cap == AW'(a) && !addr_bad, "R4 burst header",
            {wcnt_cap, waddr_cap}, {CW'(n), AW'(a)});
        chk(wbe_cap == m, "R8 byte enables", wbe_cap, m);
        for (int i = 0; i < n; i++)
            chk(mem[8'(a + i)] == 32'hA500_0000 + s0 + i, "R7 data order", mem[8'(a + i)],
                32'hA500_0000 + s0 + i);
        chk(mem[8'(a + n)] == sentinel, "R3 no extra beat", mem[8'(a + n)], sentinel);
        sent_before = 0;
    endtask

    task automatic t_read(input int a, input int n, input logic [15:0] wp, input logic [15:0] gp);
        int c0, r0;
        bit rv;
        wpat_cfg = wp; gap_cfg = gp;
        @(negedge clk);
        c0 = cap_n; r0 = rcmds;
        pulse_go(AW'(a), n, 1'b0, 4'hF);
        chk(av_read, "R5 read raised", av_read, 1);
        wait_done("R12 read done", rv);
        chk(rv, "R12 done with last word", rv, 1);
        chk(rcmds - r0 == 1, "R5 one request", rcmds - r0, 1);
        chk(cap_n - c0 == n, "R6 word count", cap_n - c0, n);
        for (int i = 0; i < n; i++)
            chk(cap[c0 + i] == mem[8'(a + i)], "R6 order", cap[c0 + i], mem[8'(a + i)]);
    endtask

    task automatic t_ignore();
        int w0, c0;
        bit rv;
        logic [DW-1:0] keep;
        wpat_cfg = 16'hFFFE; gap_cfg = 16'h00F0;
        @(negedge clk);
        w0 = wtotal; c0 = cap_n; keep = mem[8'hE0];
        pulse_go(16'h00A0, 3, 1'b0, 4'hF);
        pulse_go(16'h00E0, 2, 1'b1, 4'hF);
        wait_done("R11 read done", rv);
        repeat (4) @(negedge clk);
        chk(wtotal == w0 && mem[8'hE0] == keep, "R11 go ignored", wtotal - w0, 0);
        chk(cap_n - c0 == 3, "R11 read intact", cap_n - c0, 3);
        c0 = cap_n;
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        repeat (2) @(negedge clk);
        chk(cap_n == c0 && !busy, "R11 stray valid ignored", cap_n - c0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_write(16'h10, 4, 4'hF, 16'h0000);
        t_write(16'h30, 5, 4'h5, 16'b0110_1001_1100_0111);
        t_write(16'h50, 15, 4'h1, 16'b0011_0000_1010_0001);
        t_write(16'h80, 1, 4'h8, 16'b1110_0000_0000_0111);
        t_read(16'h10, 4, 16'b0000_0000_0000_1111, 16'b0101_0101_0011_0000);
        t_read(16'hA0, 15, 16'b1001_0010_0100_1001, 16'b1100_1100_0001_1010);
        t_read(16'h50, 1, 16'h0000, 16'h0000);
        t_read(16'h30, 5, 16'h8001, 16'hFFF0);
        t_ignore();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule